// File: doc/BRIEF.md
# Control Endpoint Stage Handshake Controller

This block picks the handshake that a USB device control endpoint returns on each token of a control transfer. Firmware arms the stages through a small register with a write strobe. One bit arms the data stage, one bit arms the status stage, and one bit halts the endpoint. The token layer reports each SETUP, OUT or IN token with a one-cycle strobe. It also reports when the host has acknowledged a packet the endpoint sent. One cycle after each token strobe, the block emits a registered one-hot response code with a valid pulse.

Every stage answers NAK until firmware arms it. The hardware drops each arm bit itself when the stage's token completes. An OUT token clears its arm on the cycle it is acknowledged. A packet sent in answer to an IN token clears its arm only when the host's acknowledgement arrives, so an IN that the host does not acknowledge is answered again. A SETUP token is always accepted and returns the endpoint to a clean state, ready for a new transfer. The endpoint index is already resolved upstream. Packet encoding, the FIFOs and the PHY are outside this block.

Top module: `ctl_ep_handshake`

## Requirements
- R1: Each cycle with `tok_valid` high produces `resp_valid` high for exactly one cycle, one clock later, and `resp_valid` is low otherwise. `resp_code` is one-hot: ACK=5'b00001, NAK=5'b00010, STALL=5'b00100, ZLP=5'b01000, DATA=5'b10000. `tok_kind` encodes SETUP=0, OUT=1 and IN=2.
- R2: A SETUP token is always answered ACK, even while halted. On the same edge it clears the halt bit, both arm bits and any pending host acknowledgement.
- R3: Once the data arm bit is set, an OUT token is answered ACK and the data arm bit clears on that edge. A second OUT that follows is answered NAK.
- R4: Once the data arm bit is set, an IN token is answered DATA. The data arm bit stays set until `host_ack` arrives after that response, so an IN repeated without `host_ack` is again answered DATA.
- R5: While the status arm bit is set and the data arm bit is clear, an IN token is answered ZLP and the status arm bit clears on the following `host_ack`. An OUT token is answered ACK and clears the status arm bit on that edge.
- R6: A non-SETUP token that arrives while neither arm bit is set, and while the halt is not in force, is answered NAK.
- R7: While the halt bit is set and `ep_iso` is low, every non-SETUP token is answered STALL. With `ep_iso` high the halt bit has no effect on the response.
- R8: Register layout: bit 0 is halt (read/write), bit 1 is status arm (read/write) and bit 2 is data arm (write-only, reads 0). Bits 7 to 3 are reserved: writes to them are ignored and they read 0. A write loads bits 2 to 0 from `cfg_wdata`.
- R9: When a register write and a hardware clear of the same bit fall on the same edge, the bit ends cleared.
- R10: After reset `cfg_rdata` is 0, `resp_valid` is low and both arm bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read view |
| tok_valid | input | 1 | Token strobe, one cycle per token |
| tok_kind | input | 2 | Token type: 0 SETUP, 1 OUT, 2 IN |
| ep_iso | input | 1 | Endpoint is configured as isochronous |
| host_ack | input | 1 | Host acknowledged the last packet sent |
| resp_valid | output | 1 | Response strobe |
| resp_code | output | 5 | One-hot handshake code |

## Verification
The hardest situations to reach are the same-edge collisions: a firmware write that lands on the edge where the hardware clears the same bit. Examples are a data-arm write together with the OUT token that consumes the arm, a status-arm write together with the `host_ack` that retires a ZLP, and a write that sets the halt bit on the edge of a SETUP token. The stimulus table drives the write strobe and the token or acknowledgement in the same vector. It then reads the register, or sends one more token, to show which side won. Pending IN acknowledgements are covered by repeating an IN without `host_ack`, and by sending `host_ack` on its own between tokens.

// File: rtl/ctl_hs_pkg.sv
package ctl_hs_pkg;
  localparam int RESP_W = 5;

  typedef enum logic [1:0] {
    TK_SETUP = 2'd0,
    TK_OUT   = 2'd1,
    TK_IN    = 2'd2
  } tok_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_DATA = 2'd1,
    PEND_ZLP  = 2'd2
  } pend_e;

  localparam logic [RESP_W-1:0] HS_ACK   = 5'b00001;
  localparam logic [RESP_W-1:0] HS_NAK   = 5'b00010;
  localparam logic [RESP_W-1:0] HS_STALL = 5'b00100;
  localparam logic [RESP_W-1:0] HS_ZLP   = 5'b01000;
  localparam logic [RESP_W-1:0] HS_DATA  = 5'b10000;
endpackage

// File: rtl/ctl_hs_decide.sv
module ctl_hs_decide
  import ctl_hs_pkg::*;
(
  input  logic              tok_valid,
  input  tok_e              tok_kind,
  input  logic              ep_iso,
  input  logic              halt,
  input  logic              data_arm,
  input  logic              stat_arm,
  output logic [RESP_W-1:0] code,
  output logic              clr_all,
  output logic              clr_data,
  output logic              clr_stat,
  output pend_e             pend_new
);
  logic halted;
  assign halted = halt && !ep_iso;

  always_comb begin
    code     = HS_NAK;
    clr_all  = 1'b0;
    clr_data = 1'b0;
    clr_stat = 1'b0;
    pend_new = PEND_NONE;
    if (tok_valid) begin
      if (tok_kind == TK_SETUP) begin
        code    = HS_ACK;
        clr_all = 1'b1;
      end else if (halted) begin
        code = HS_STALL;
      end else if (data_arm) begin
        if (tok_kind == TK_OUT) begin
          code     = HS_ACK;
          clr_data = 1'b1;
        end else if (tok_kind == TK_IN) begin
          code     = HS_DATA;
          pend_new = PEND_DATA;
        end
      end else if (stat_arm) begin
        if (tok_kind == TK_OUT) begin
          code     = HS_ACK;
          clr_stat = 1'b1;
        end else if (tok_kind == TK_IN) begin
          code     = HS_ZLP;
          pend_new = PEND_ZLP;
        end
      end
    end
  end
endmodule

// File: rtl/ctl_hs_regs.sv
module ctl_hs_regs
  import ctl_hs_pkg::*;
#(
  parameter int DW       = 8,
  parameter int HALT_BIT = 0,
  parameter int STAT_BIT = 1,
  parameter int DATA_BIT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          tok_valid,
  input  logic          host_ack,
  input  logic          clr_all,
  input  logic          clr_data,
  input  logic          clr_stat,
  input  pend_e         pend_new,
  output logic          halt_q,
  output logic          data_q,
  output logic          stat_q,
  output logic [DW-1:0] rdata
);
  pend_e pend_q, pend_n;
  logic  halt_n, data_n, stat_n;
  logic  ack_data, ack_zlp;
  logic  unused_wdata;

  assign unused_wdata = ^wdata;
  assign ack_data = host_ack && (pend_q == PEND_DATA);
  assign ack_zlp  = host_ack && (pend_q == PEND_ZLP);

  always_comb begin
    halt_n = wr ? wdata[HALT_BIT] : halt_q;
    data_n = wr ? wdata[DATA_BIT] : data_q;
    stat_n = wr ? wdata[STAT_BIT] : stat_q;
    // hardware clears are applied last so they win over a write
    if (clr_all) halt_n = 1'b0;
    if (clr_all || clr_data || ack_data) data_n = 1'b0;
    if (clr_all || clr_stat || ack_zlp)  stat_n = 1'b0;
    if (tok_valid)     pend_n = pend_new;
    else if (host_ack) pend_n = PEND_NONE;
    else               pend_n = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q <= 1'b0;
      data_q <= 1'b0;
      stat_q <= 1'b0;
      pend_q <= PEND_NONE;
    end else begin
      halt_q <= halt_n;
      data_q <= data_n;
      stat_q <= stat_n;
      pend_q <= pend_n;
    end
  end

  always_comb begin
    rdata           = '0;
    rdata[HALT_BIT] = halt_q;
    rdata[STAT_BIT] = stat_q;
  end
endmodule

// File: rtl/ctl_hs_resp.sv
module ctl_hs_resp
  import ctl_hs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tok_valid,
  input  logic [RESP_W-1:0] code,
  output logic              resp_valid,
  output logic [RESP_W-1:0] resp_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_code  <= '0;
    end else begin
      resp_valid <= tok_valid;
      resp_code  <= tok_valid ? code : '0;
    end
  end
endmodule

// File: rtl/ctl_ep_handshake.sv
module ctl_ep_handshake
  import ctl_hs_pkg::*;
#(
  parameter int DW       = 8,
  parameter int HALT_BIT = 0,
  parameter int STAT_BIT = 1,
  parameter int DATA_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic              ep_iso,
  input  logic              host_ack,
  output logic              resp_valid,
  output logic [RESP_W-1:0] resp_code
);
  logic              halt_q, data_q, stat_q;
  logic              clr_all, clr_data, clr_stat;
  logic [RESP_W-1:0] code;
  pend_e             pend_new;
  tok_e              kind;

  assign kind = tok_e'(tok_kind);

  ctl_hs_decide u_decide (
    .tok_valid (tok_valid),
    .tok_kind  (kind),
    .ep_iso    (ep_iso),
    .halt      (halt_q),
    .data_arm  (data_q),
    .stat_arm  (stat_q),
    .code      (code),
    .clr_all   (clr_all),
    .clr_data  (clr_data),
    .clr_stat  (clr_stat),
    .pend_new  (pend_new)
  );

  ctl_hs_regs #(
    .DW       (DW),
    .HALT_BIT (HALT_BIT),
    .STAT_BIT (STAT_BIT),
    .DATA_BIT (DATA_BIT)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr        (cfg_wr),
    .wdata     (cfg_wdata),
    .tok_valid (tok_valid),
    .host_ack  (host_ack),
    .clr_all   (clr_all),
    .clr_data  (clr_data),
    .clr_stat  (clr_stat),
    .pend_new  (pend_new),
    .halt_q    (halt_q),
    .data_q    (data_q),
    .stat_q    (stat_q),
    .rdata     (cfg_rdata)
  );

  ctl_hs_resp u_resp (
    .clk        (clk),
    .rst        (rst),
    .tok_valid  (tok_valid),
    .code       (code),
    .resp_valid (resp_valid),
    .resp_code  (resp_code)
  );
endmodule

// File: rtl/ctl_ep_handshake_chk.sv
module ctl_ep_handshake_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] cfg_rdata,
  input logic          tok_valid,
  input logic [1:0]    tok_kind,
  input logic          ep_iso,
  input logic          resp_valid,
  input logic [4:0]    resp_code
);
  // R1
  resp_follows_tok_chk: assert property (@(posedge clk) disable iff (rst)
    tok_valid |=> resp_valid);
  // R1
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !tok_valid |=> !resp_valid);
  // R1
  resp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $onehot(resp_code));
  // R2
  setup_ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_kind == 2'd0) |=> (resp_code == 5'b00001 && cfg_rdata[1:0] == 2'b00));
  // R7
  halt_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_kind != 2'd0 && cfg_rdata[0] && !ep_iso) |=> resp_code == 5'b00100);
  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[DW-1:2] == '0);
endmodule

bind ctl_ep_handshake ctl_ep_handshake_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_rdata  (cfg_rdata),
  .tok_valid  (tok_valid),
  .tok_kind   (tok_kind),
  .ep_iso     (ep_iso),
  .resp_valid (resp_valid),
  .resp_code  (resp_code)
);

// File: tb/tb_ctl_ep_handshake.sv
`timescale 1ns/1ps
module tb_ctl_ep_handshake;
  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_wr;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       tok_valid;
  logic [1:0] tok_kind;
  logic       ep_iso;
  logic       host_ack;
  logic       resp_valid;
  logic [4:0] resp_code;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ctl_ep_handshake dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .ep_iso(ep_iso), .host_ack(host_ack), .resp_valid(resp_valid),
    .resp_code(resp_code)
  );

  typedef struct packed {
    logic       wr;
    logic [7:0] wdata;
    logic       tv;
    logic [1:0] kind;
    logic       iso;
    logic       hack;
    logic [4:0] code;
    logic [7:0] rd;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 31;
  // kind: 0 SETUP, 1 OUT, 2 IN; code: ACK 1, NAK 2, STALL 4, ZLP 8, DATA 16
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0, 5'd1,  8'h00, 4'd2},  // R2 setup ack
    '{1'b0, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0, 5'd2,  8'h00, 4'd6},  // R6 unarmed OUT nak
    '{1'b1, 8'h04, 1'b0, 2'd0, 1'b0, 1'b0, 5'd0,  8'h00, 4'd8},  // R8 data arm reads 0
    '{1'b0, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0, 5'd1,  8'h00, 4'd3},  // R3 OUT ack
    '{1'b0, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0, 5'd2,  8'h00, 4'd3},  // R3 arm consumed
    '{1'b1, 8'h02, 1'b0, 2'd0, 1'b0, 1'b0, 5'd0,  8'h02, 4'd8},  // R8 status readback
    '{1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 5'd8,  8'h02, 4'd5},  // R5 IN zlp
    '{1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b1, 5'd0,  8'h00, 4'd5},  // R5 ack clears
    '{1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 5'd2,  8'h00, 4'd6},  // R6 IN nak
    '{1'b0, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0, 5'd1,  8'h00, 4'd2},  // R2
    '{1'b1, 8'h04, 1'b0, 2'd0, 1'b0, 1'b0, 5'd0,  8'h00, 4'd4},  // R4 arm
    '{1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 5'd16, 8'h00, 4'd4},  // R4 IN data
    '{1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 5'd16, 8'h00, 4'd4},  // R4 retry no ack
    '{1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b1, 5'd0,  8'h00, 4'd4},  // R4 host ack
    '{1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 5'd2,  8'h00, 4'd4},  // R4 now nak
    '{1'b1, 8'h01, 1'b0, 2'd0, 1'b0, 1'b0, 5'd0,  8'h01, 4'd8},  // R8 halt readback
    '{1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 5'd4,  8'h01, 4'd7},  // R7 stall
    '{1'b0, 8'h00, 1'b1, 2'd1, 1'b1, 1'b0, 5'd2,  8'h01, 4'd7},  // R7 iso ignores halt
    '{1'b0, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0, 5'd1,  8'h00, 4'd2},  // R2 clears halt
    '{1'b1, 8'h02, 1'b0, 2'd0, 1'b0, 1'b0, 5'd0,  8'h02, 4'd5},  // R5 arm status
    '{1'b0, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0, 5'd1,  8'h00, 4'd5},  // R5 OUT ack clears
    '{1'b1, 8'hE2, 1'b0, 2'd0, 1'b0, 1'b0, 5'd0,  8'h02, 4'd8},  // R8 reserved ignored
    '{1'b0, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0, 5'd1,  8'h00, 4'd2},  // R2 clears status
    '{1'b1, 8'h02, 1'b0, 2'd0, 1'b0, 1'b0, 5'd0,  8'h02, 4'd5},  // R5
    '{1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 5'd8,  8'h02, 4'd5},  // R5 zlp
    '{1'b1, 8'h02, 1'b0, 2'd0, 1'b0, 1'b1, 5'd0,  8'h00, 4'd9},  // R9 ack beats write
    '{1'b1, 8'h04, 1'b0, 2'd0, 1'b0, 1'b0, 5'd0,  8'h00, 4'd9},  // R9 arm data
    '{1'b1, 8'h04, 1'b1, 2'd1, 1'b0, 1'b0, 5'd1,  8'h00, 4'd9},  // R9 OUT clear vs write
    '{1'b0, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0, 5'd2,  8'h00, 4'd9},  // R9 clear won
    '{1'b1, 8'h01, 1'b0, 2'd0, 1'b0, 1'b0, 5'd0,  8'h01, 4'd7},  // R7 halt
    '{1'b1, 8'h03, 1'b1, 2'd0, 1'b0, 1'b0, 5'd1,  8'h00, 4'd9}   // R9 setup beats write
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cfg_wr = 1'b0; cfg_wdata = 8'h00; tok_valid = 1'b0;
    tok_kind = 2'd0; ep_iso = 1'b0; host_ack = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10", cfg_rdata, 0);
    check("R10", resp_valid, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cfg_wr = VECS[i].wr; cfg_wdata = VECS[i].wdata;
      tok_valid = VECS[i].tv; tok_kind = VECS[i].kind;
      ep_iso = VECS[i].iso; host_ack = VECS[i].hack;
      @(posedge clk);
      #1;
      check($sformatf("R%0d v%0d valid", VECS[i].req, i), resp_valid, VECS[i].tv);
      if (VECS[i].tv)
        check($sformatf("R%0d v%0d code", VECS[i].req, i), resp_code, VECS[i].code);
      check($sformatf("R%0d v%0d rdata", VECS[i].req, i), cfg_rdata, VECS[i].rd);
    end

    // R1 response strobe lasts one cycle
    @(negedge clk);
    idle();
    @(posedge clk);
    #1;
    check("R1 pulse width", resp_valid, 0);

    // R10 reset mid-flow clears halt, status and data arm
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 8'h07;
    @(negedge clk);
    idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 rdata", cfg_rdata, 0);
    tok_valid = 1'b1; tok_kind = 2'd1;
    @(posedge clk);
    #1;
    check("R10 data arm cleared", resp_code, 5'd2);
    @(negedge clk);
    idle();
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule